// File: doc/BRIEF.md
# Downstream Port Status and Command Register

This block is the control and status register for one downstream port of a host root hub. Software reads a 32-bit word. The low half holds the live port state: attached, enabled, suspended, in reset, powered, and low-speed. The high half holds sticky change flags. A write is a command word. Each bit position set to 1 requests one action, and a bit written as 0 requests nothing. The same bit position can therefore mean one thing on read and a different thing on write.

Connect and speed detection arrive from the line interface. A transaction-in-progress flag from the schedule engine holds back any command that arrives while a transaction runs. A bit-time tick times the port reset pulse. The outputs drive the port reset signalling and the port power switch. A one-cycle change pulse goes to the interrupt logic.

The block holds three state machines:
- The link tracker has the states LINK_DETACHED and LINK_ATTACHED. It moves to LINK_ATTACHED when a device appears and back to LINK_DETACHED when it leaves. With the fixed-device option it goes to LINK_ATTACHED once after reset and stays there.
- The command holder has the states CMD_IDLE and CMD_HOLD. It goes from CMD_IDLE to CMD_HOLD when a write arrives while the transaction flag is high. It goes from CMD_HOLD back to CMD_IDLE at the first cycle in which the flag is low, and it applies the held command in that cycle.
- The reset sequencer has the states RST_OFF, RST_DRIVE and RST_DONE. It goes from RST_OFF to RST_DRIVE on an accepted reset command. It goes from RST_DRIVE to RST_DONE after the tick count has elapsed. It goes from RST_DONE to RST_OFF one cycle later, and that is when the completion is posted. A disconnect sends RST_DRIVE or RST_DONE straight to RST_OFF.

Top module: `rh_port_status`

## Requirements
- R1: While reset is asserted, `rd_data` reads all zeros and `port_reset_drive`, `port_power` and `change_pulse` are 0 (removable-device mode).
- R2: Bit 0 reads 1 from the clock edge after `line_connect` is sampled high, and 0 from the edge after it is sampled low. Every connect or disconnect sets bit 16 (connect change). `change_pulse` is high for exactly the cycle in which bit 16 or bit 20 goes from 0 to 1.
- R3: Writing 1 to bit 16 or bit 20 clears that flag. Writing 0 leaves it unchanged. If hardware sets a flag in the same cycle that a write clears it, the flag ends up set.
- R4: Writing 1 to bit 0 clears the enable status in bit 1. No write ever changes bit 0.
- R5: While attached, writing 1 to bit 1 sets enable, writing 1 to bit 2 sets suspend (read at bit 2), and writing 1 to bit 3 clears suspend. A clear wins over a set in the same word.
- R6: While attached, writing 1 to bit 4 sets bit 4 and drives `port_reset_drive` high for exactly `RESET_TICKS` ticks of `bit_tick`. One cycle later, bit 4 clears, bit 20 (reset change) sets, and enable sets.
- R7: A write of 1 to bit 1, 2 or 4 while detached leaves bits 1, 2 and 4 unchanged and sets bit 16 instead.
- R8: Writing 1 to bit 8 sets port power and writing 1 to bit 9 clears it. Clear wins when both bits are written together. `port_power` follows bit 8.
- R9: Bit 9 reads the sampled `line_low_speed` (1 = low speed) only while bit 0 is 1. Otherwise it reads 0.
- R10: A write that arrives while `xfer_busy` is high changes nothing. It is held, merged by OR with later held writes, and applied in the first cycle in which `xfer_busy` is low.
- R11: A disconnect clears enable and suspend. It also ends any port reset without setting bit 20.
- R12: With `FIXED_DEVICE` set, bit 0 always reads 1, and bit 16 is set only once, in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low root hub reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word (1 = request) |
| rd_data | output | 32 | Status and change flags |
| line_connect | input | 1 | Device presence from line interface |
| line_low_speed | input | 1 | Speed detect, 1 = low speed |
| xfer_busy | input | 1 | Transaction in progress |
| bit_tick | input | 1 | Bit-time tick for reset timing |
| port_reset_drive | output | 1 | Port reset signalling active |
| port_power | output | 1 | Port power switch |
| change_pulse | output | 1 | One-cycle pulse when a change flag sets |

## Verification
The command decoder is exercised with single-bit command words while attached, with all-zero words, and with words that combine a set and a clear for the same bit. These show which bit drives which action and which one takes priority. The same commands are then issued while detached, which separates the normal action from the refusal path that raises the connect change flag. Writes issued while `xfer_busy` is high show that commands are held and merged rather than dropped. A full reset sequence and a reset cut short by a disconnect show the difference between normal completion and an abort.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

    localparam int unsigned REG_W      = 32;
    // Read/write bit positions decoded by software.
    localparam int unsigned BIT_CONN   = 0;   // read attached / write clear enable
    localparam int unsigned BIT_ENA    = 1;   // read enable / write set enable
    localparam int unsigned BIT_SUSP   = 2;   // read suspend / write set suspend
    localparam int unsigned BIT_WAKE   = 3;   // write clear suspend
    localparam int unsigned BIT_RST    = 4;   // read reset active / write start reset
    localparam int unsigned BIT_PWR    = 8;   // read power / write set power
    localparam int unsigned BIT_LS     = 9;   // read low speed / write clear power
    localparam int unsigned BIT_CSC    = 16;  // connect change flag
    localparam int unsigned BIT_PRSC   = 20;  // reset complete flag

    typedef struct packed {
        logic clr_ena;
        logic set_ena;
        logic set_susp;
        logic clr_susp;
        logic set_rst;
        logic set_pwr;
        logic clr_pwr;
        logic clr_csc;
        logic clr_prsc;
    } port_cmd_t;

    localparam int unsigned CMD_W = $bits(port_cmd_t);

    typedef enum logic [0:0] {LINK_DETACHED, LINK_ATTACHED} link_state_e;
    typedef enum logic [0:0] {CMD_IDLE, CMD_HOLD} cmd_state_e;
    typedef enum logic [1:0] {RST_OFF, RST_DRIVE, RST_DONE} rst_state_e;

    function automatic port_cmd_t decode_cmd(input logic [REG_W-1:0] w);
        port_cmd_t c;
        c.clr_ena  = w[BIT_CONN];
        c.set_ena  = w[BIT_ENA];
        c.set_susp = w[BIT_SUSP];
        c.clr_susp = w[BIT_WAKE];
        c.set_rst  = w[BIT_RST];
        c.set_pwr  = w[BIT_PWR];
        c.clr_pwr  = w[BIT_LS];
        c.clr_csc  = w[BIT_CSC];
        c.clr_prsc = w[BIT_PRSC];
        return c;
    endfunction

endpackage

// File: rtl/rh_link_track.sv
module rh_link_track
    import rh_port_pkg::*;
#(
    parameter bit FIXED_DEVICE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_connect,
    input  logic line_low_speed,
    output logic attached,
    output logic low_speed,
    output logic link_event,
    output logic link_fall
);

    link_state_e state_q, state_d;
    logic        ls_q;

    always_comb begin
        if (FIXED_DEVICE) begin
            state_d = LINK_ATTACHED;
        end else begin
            unique case (state_q)
                LINK_DETACHED: state_d = line_connect ? LINK_ATTACHED : LINK_DETACHED;
                LINK_ATTACHED: state_d = line_connect ? LINK_ATTACHED : LINK_DETACHED;
                default:       state_d = LINK_DETACHED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINK_DETACHED;
            ls_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ls_q    <= line_low_speed;
        end
    end

    always_comb begin
        attached   = FIXED_DEVICE ? 1'b1 : (state_q == LINK_ATTACHED);
        low_speed  = attached & ls_q;
        link_event = (state_d != state_q);
        link_fall  = (state_q == LINK_ATTACHED) && (state_d == LINK_DETACHED);
    end

endmodule

// File: rtl/rh_cmd_hold.sv
module rh_cmd_hold
    import rh_port_pkg::*;
#(
    parameter int unsigned WIDTH = CMD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_cmd,
    input  logic             busy,
    output logic             cmd_valid,
    output logic [WIDTH-1:0] cmd_bits
);

    cmd_state_e       state_q, state_d;
    logic [WIDTH-1:0] held_q;
    logic [WIDTH-1:0] merged;

    always_comb begin
        merged = ((state_q == CMD_HOLD) ? held_q : '0) | (wr_en ? wr_cmd : '0);
        unique case (state_q)
            CMD_IDLE: state_d = (wr_en && busy) ? CMD_HOLD : CMD_IDLE;
            CMD_HOLD: state_d = busy ? CMD_HOLD : CMD_IDLE;
            default:  state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= busy ? merged : '0;
        end
    end

    always_comb begin
        cmd_valid = !busy && ((state_q == CMD_HOLD) || wr_en);
        cmd_bits  = merged;
    end

endmodule

// File: rtl/rh_reset_seq.sv
module rh_reset_seq
    import rh_port_pkg::*;
#(
    parameter int unsigned RESET_TICKS = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic tick,
    output logic drive,
    output logic active,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(RESET_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RESET_TICKS - 1);

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        unique case (state_q)
            RST_OFF:   state_d = (start && !abort) ? RST_DRIVE : RST_OFF;
            RST_DRIVE: begin
                if (abort)                     state_d = RST_OFF;
                else if (tick && cnt_q == LAST) state_d = RST_DONE;
                else                           state_d = RST_DRIVE;
            end
            RST_DONE:  state_d = RST_OFF;
            default:   state_d = RST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (state_q != RST_DRIVE) cnt_q <= '0;
        else if (tick)                cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        drive  = (state_q == RST_DRIVE);
        active = (state_q != RST_OFF);
        done   = (state_q == RST_DONE) && !abort;
    end

endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
    import rh_port_pkg::*;
#(
    parameter int unsigned RESET_TICKS  = 120000,
    parameter bit          FIXED_DEVICE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             line_connect,
    input  logic             line_low_speed,
    input  logic             xfer_busy,
    input  logic             bit_tick,
    output logic             port_reset_drive,
    output logic             port_power,
    output logic             change_pulse
);

    logic             attached, low_speed, link_event, link_fall;
    logic             cmd_valid;
    logic [CMD_W-1:0] cmd_bits;
    port_cmd_t        wr_cmd, cmd;
    logic             rst_start, rst_active, rst_done, refused;

    logic ena_q, ena_d, susp_q, susp_d, pwr_q, pwr_d;
    logic csc_q, csc_d, prsc_q, prsc_d, pulse_d;

    assign wr_cmd = decode_cmd(wr_data);

    rh_link_track #(.FIXED_DEVICE(FIXED_DEVICE)) link_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_connect   (line_connect),
        .line_low_speed (line_low_speed),
        .attached       (attached),
        .low_speed      (low_speed),
        .link_event     (link_event),
        .link_fall      (link_fall)
    );

    rh_cmd_hold #(.WIDTH(CMD_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_cmd    (wr_cmd),
        .busy      (xfer_busy),
        .cmd_valid (cmd_valid),
        .cmd_bits  (cmd_bits)
    );

    always_comb begin
        cmd       = cmd_valid ? port_cmd_t'(cmd_bits) : '0;
        rst_start = cmd.set_rst && attached;
        refused   = (cmd.set_rst || cmd.set_ena || cmd.set_susp) && !attached;
    end

    rh_reset_seq #(.RESET_TICKS(RESET_TICKS)) rseq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rst_start),
        .abort  (link_fall),
        .tick   (bit_tick),
        .drive  (port_reset_drive),
        .active (rst_active),
        .done   (rst_done)
    );

    // Next-state of status bits: later statements take priority.
    always_comb begin
        ena_d = ena_q;
        if (cmd.set_ena && attached) ena_d = 1'b1;
        if (rst_done)                ena_d = 1'b1;
        if (cmd.clr_ena)             ena_d = 1'b0;
        if (link_fall)               ena_d = 1'b0;

        susp_d = susp_q;
        if (cmd.set_susp && attached)          susp_d = 1'b1;
        if (cmd.clr_susp || rst_done || link_fall) susp_d = 1'b0;

        pwr_d = pwr_q;
        if (cmd.set_pwr) pwr_d = 1'b1;
        if (cmd.clr_pwr) pwr_d = 1'b0;

        csc_d = csc_q;
        if (cmd.clr_csc)          csc_d = 1'b0;
        if (link_event || refused) csc_d = 1'b1;

        prsc_d = prsc_q;
        if (cmd.clr_prsc) prsc_d = 1'b0;
        if (rst_done)     prsc_d = 1'b1;

        pulse_d = (csc_d && !csc_q) || (prsc_d && !prsc_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q        <= 1'b0;
            susp_q       <= 1'b0;
            pwr_q        <= 1'b0;
            csc_q        <= 1'b0;
            prsc_q       <= 1'b0;
            change_pulse <= 1'b0;
        end else begin
            ena_q        <= ena_d;
            susp_q       <= susp_d;
            pwr_q        <= pwr_d;
            csc_q        <= csc_d;
            prsc_q       <= prsc_d;
            change_pulse <= pulse_d;
        end
    end

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_CONN] = attached;
        rd_data[BIT_ENA]  = ena_q;
        rd_data[BIT_SUSP] = susp_q;
        rd_data[BIT_RST]  = rst_active;
        rd_data[BIT_PWR]  = pwr_q;
        rd_data[BIT_LS]   = low_speed;
        rd_data[BIT_CSC]  = csc_q;
        rd_data[BIT_PRSC] = prsc_q;
        port_power        = pwr_q;
    end

endmodule

// File: rtl/rh_port_status_chk.sv
module rh_port_status_chk #(
    parameter bit FIXED_DEVICE = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_busy,
    input logic [31:0] rd_data,
    input logic        port_reset_drive,
    input logic        change_pulse
);

    p_ls_needs_conn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |-> !rd_data[9]);

    p_disconnect_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[0]) |-> (!rd_data[1] && rd_data[16]));

    p_reset_needs_conn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_reset_drive) |-> (rd_data[0] && rd_data[4]));

    p_reset_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_data[4]) && rd_data[0]) |-> rd_data[20]);

    p_busy_holds_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> $stable(rd_data[8]));

    p_pulse_on_csc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[16]) |-> change_pulse);

    generate
        if (FIXED_DEVICE) begin : g_fixed
            p_fixed_conn_r12: assert property (@(posedge clk) disable iff (!rst_n)
                rd_data[0]);
        end
    endgenerate

endmodule

bind rh_port_status rh_port_status_chk #(.FIXED_DEVICE(FIXED_DEVICE)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .xfer_busy        (xfer_busy),
    .rd_data          (rd_data),
    .port_reset_drive (port_reset_drive),
    .change_pulse     (change_pulse)
);

// File: tb/rh_port_status_tb.sv
module rh_port_status_tb_top;

    localparam int unsigned TICKS = 20;
    localparam int NV = 20;
    // {connect, low_speed, busy, wr_en, wr_data[31:0], expected rd_data[31:0], expected pulse}
    localparam logic [68:0] VEC [NV] = '{
        {4'b1000, 32'h0000_0000, 32'h0001_0001, 1'b1},  // R2 connect
        {4'b1001, 32'h0001_0000, 32'h0000_0001, 1'b0},  // R3 clear csc
        {4'b1001, 32'h0000_0100, 32'h0000_0101, 1'b0},  // R8 power on
        {4'b1001, 32'h0000_0002, 32'h0000_0103, 1'b0},  // R5 enable
        {4'b1001, 32'h0000_0004, 32'h0000_0107, 1'b0},  // R5 suspend
        {4'b1001, 32'h0000_0008, 32'h0000_0103, 1'b0},  // R5 resume
        {4'b1001, 32'h0000_0000, 32'h0000_0103, 1'b0},  // R3 zero word
        {4'b1001, 32'h0000_0001, 32'h0000_0101, 1'b0},  // R4 clear enable
        {4'b1100, 32'h0000_0000, 32'h0000_0301, 1'b0},  // R9 low speed
        {4'b1111, 32'h0000_0002, 32'h0000_0301, 1'b0},  // R10 held
        {4'b1111, 32'h0000_0200, 32'h0000_0301, 1'b0},  // R10 held merge
        {4'b1100, 32'h0000_0000, 32'h0000_0203, 1'b0},  // R10 applied
        {4'b1101, 32'h0000_0300, 32'h0000_0203, 1'b0},  // R8 clear wins
        {4'b0100, 32'h0000_0000, 32'h0001_0000, 1'b1},  // R11 disconnect
        {4'b0001, 32'h0001_0000, 32'h0000_0000, 1'b0},  // R3
        {4'b0001, 32'h0000_0002, 32'h0001_0000, 1'b1},  // R7 enable refused
        {4'b0001, 32'h0001_0000, 32'h0000_0000, 1'b0},  // R3
        {4'b0001, 32'h0000_0010, 32'h0001_0000, 1'b1},  // R7 reset refused
        {4'b0001, 32'h0001_0004, 32'h0001_0000, 1'b0},  // R7 set beats clear
        {4'b0001, 32'h0001_0000, 32'h0000_0000, 1'b0}   // R3
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:               return "R2";
            2, 12:           return "R8";
            3, 4, 5:         return "R5";
            7:               return "R4";
            8:               return "R9";
            9, 10, 11:       return "R10";
            13:              return "R11";
            15, 17, 18:      return "R7";
            default:         return "R3";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        line_connect = 1'b0, line_low_speed = 1'b0, xfer_busy = 1'b0, bit_tick = 1'b0;
    logic [31:0] rd_data, rd_fix;
    logic        port_reset_drive, port_power, change_pulse;
    logic        drv_fix, pwr_fix, pulse_fix;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rh_port_status #(.RESET_TICKS(TICKS), .FIXED_DEVICE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .line_connect(line_connect), .line_low_speed(line_low_speed), .xfer_busy(xfer_busy),
        .bit_tick(bit_tick), .port_reset_drive(port_reset_drive), .port_power(port_power),
        .change_pulse(change_pulse));

    rh_port_status #(.RESET_TICKS(TICKS), .FIXED_DEVICE(1'b1)) dut_fix_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_fix),
        .line_connect(line_connect), .line_low_speed(line_low_speed), .xfer_busy(xfer_busy),
        .bit_tick(bit_tick), .port_reset_drive(drv_fix), .port_power(pwr_fix),
        .change_pulse(pulse_fix));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        step();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int drv_cycles;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_data in reset", rd_data, 32'h0);
        check("R1 outputs in reset", {29'b0, port_reset_drive, port_power, change_pulse}, 32'h0);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", rd_data, 32'h0);
        // R12 fixed device: attached and flagged once after reset
        check("R12 fixed conn and csc", rd_fix & 32'h0001_0001, 32'h0001_0001);

        for (int i = 0; i < NV; i++) begin
            line_connect   = VEC[i][68];
            line_low_speed = VEC[i][67];
            xfer_busy      = VEC[i][66];
            wr_en          = VEC[i][65];
            wr_data        = VEC[i][64:33];
            step();
            check($sformatf("%s vector %0d rd_data", vec_tag(i), i), rd_data, VEC[i][32:1]);
            check($sformatf("%s vector %0d pulse", vec_tag(i), i), {31'b0, change_pulse}, {31'b0, VEC[i][0]});
        end
        wr_en = 1'b0; wr_data = '0; xfer_busy = 1'b0; line_low_speed = 1'b0;
        check("R8 power pin", {31'b0, port_power}, 32'h0);

        // R6 full reset sequence
        line_connect = 1'b1;
        step();
        write(32'h0001_0000);
        bit_tick = 1'b1;
        write(32'h0000_0010);
        check("R6 reset active", {rd_data[4], port_reset_drive}, 32'h3);
        drv_cycles = 1;
        for (int k = 0; k < 1000 && rd_data[4]; k++) begin
            step();
            if (port_reset_drive) drv_cycles++;
        end
        check("R6 drive length", drv_cycles, TICKS);
        check("R6 end state", rd_data & 32'h0011_0013, 32'h0010_0003);
        check("R6 end pulse", {31'b0, change_pulse}, 32'h1);
        write(32'h0010_0000);
        check("R3 clear reset flag", rd_data & 32'h0010_0000, 32'h0);

        // R11 reset aborted by disconnect
        write(32'h0000_0010);
        check("R11 reset started", {31'b0, port_reset_drive}, 32'h1);
        step(); step();
        line_connect = 1'b0;
        step();
        check("R11 abort state", rd_data & 32'h0011_0013, 32'h0001_0000);
        check("R11 drive off", {31'b0, port_reset_drive}, 32'h0);
        step();
        check("R11 no late flag", rd_data & 32'h0010_0010, 32'h0);

        // R12 fixed device ignores the line
        check("R12 fixed stays attached", rd_fix & 32'h0001_0001, 32'h0000_0001);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule